// File: doc/BRIEF.md
# DDR2 Read Command Scheduler

This block turns an in-order stream of memory read requests into DDR2 commands on one command bus. Each request names a bank, a row and a column. The block remembers, for every bank, whether a row is open and which one. With that record it picks one of three paths for each request. A page hit goes straight to a column read. A closed bank is activated first. A bank holding a different row is precharged, then re-activated, then read.

Every command waits for its timing gaps. Activates to any two banks keep a minimum spacing, and reads are spaced by half the burst length. Each bank also tracks three gaps of its own: activate to read, read to precharge, and precharge to activate. Requests complete strictly in arrival order. The one exception concerns the request second in line: when the head request cannot issue anything in a cycle, that request may have its bank activated early. This lets activates overlap reads that are already under way. A strobe marks the cycle in which read data is due on the data bus, a CAS latency after each read.

The block sits between a request source and the memory's command pins. Refresh, writes, data capture and strobe handling belong to other blocks.

Top module: `ddr2_rd_sched`

## Requirements
- R1: A request whose bank already holds the requested row gets a READ with no ACT and no PRE before it.
- R2: A READ to a bank is issued no earlier than TRCD (default 3) cycles after that bank's ACT. A request to a closed bank gets an ACT, then its READ.
- R3: Two ACT commands, to any banks, are at least TRRD (default 2) cycles apart.
- R4: Two READ commands, to any banks, are at least BURST/2 (default 2) cycles apart.
- R5: A request to a bank holding another row causes a PRE to that bank no earlier than TRTP (default 2) cycles after its last READ. Then comes an ACT with the new row, no earlier than TRP (default 3) cycles after the PRE, and then the READ.
- R6: At most one command appears per cycle on cmd_o, encoded NOP=0, ACT=1, READ=2, PRE=3. cmd_addr_o carries the row (zero-extended) on ACT, the column on READ, and zero on PRE and NOP. cmd_bank_o carries the target bank, and zero on NOP. When no command is legal, NOP is driven.
- R7: data_due_o is high exactly CL (default 3) cycles after each READ appears on cmd_o, and is low otherwise.
- R8: READs are issued in request arrival order. If the head request issues nothing in a cycle, an ACT may go to the second queued request. This needs that request's bank to be closed and different from the head's bank, and its TRP and TRRD gaps to be met.
- R9: req_ready_o is high exactly when fewer than DEPTH (default 4) requests are queued. A request is taken on a clock edge where req_valid_i and req_ready_o are both high.
- R10: A synchronous active-high reset empties the queue, closes all banks, drives NOP and clears all gaps, so the first ACT may issue at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Queue can take a request |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| cmd_o | output | 2 | Command code: NOP, ACT, READ, PRE |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | max(ROW_W, COL_W) | Row for ACT, column for READ |
| data_due_o | output | 1 | Read data expected on the data bus this cycle |

## Verification
Some properties are checked by assertions on every cycle. Each gap timer is tied to its own elapsed-cycle count. No ACT may reach an open bank, and no READ or PRE may reach a closed one. A bank sees at most one command per cycle. Back-to-back ACTs and back-to-back READs are ruled out, a NOP carries a zero bank and address, and the queue never overflows or underflows. Other behaviours only the bench can show, by comparing every output each cycle with a timestamp-based model: in-order completion, when the early activate for the second request is allowed, exact command spacing in a mixed hit, miss and conflict sequence, and where the data-due strobe lands.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_READ = 2'b10,
        CMD_PRE  = 2'b11
    } ddr_cmd_e;

    // bits needed to hold values 0..v
    function automatic int span_w(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer
    import ddr2_sched_pkg::*;
#(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic ok_o
);
    localparam int CW = span_w(GAP);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(GAP - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ok_o = (cnt_q == '0);

    // independent elapsed-cycle count, saturating at GAP
    logic [CW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= CW'(GAP);
        end else if (start_i) begin
            age_q <= CW'(1);
        end else if (age_q != CW'(GAP)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R2 R3 R4 R5: the gap reports open only once GAP cycles have passed
    a_r2_gap_elapsed: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> (age_q == CW'(GAP)));
    a_r3_start_only_when_open: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ok_o);

endmodule

// File: rtl/ddr2_req_fifo.sv
module ddr2_req_fifo #(
    parameter int W     = 27,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push_i,
    input  logic [W-1:0]                  push_data_i,
    input  logic                          pop_i,
    output logic [W-1:0]                  head_o,
    output logic [W-1:0]                  next_o,
    output logic [$clog2(DEPTH+1)-1:0]    cnt_o
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= wr_q + 1'b1;
            if (pop_i)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    assign head_o = mem[rd_q];
    assign next_o = mem[PW'(rd_q + 1'b1)];
    assign cnt_o  = cnt_q;

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (cnt_q < CW'(DEPTH)));
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
    import ddr2_sched_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int TRCD  = 3,
    parameter int TRTP  = 2,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             rd_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_ok_o,
    output logic             rtp_ok_o,
    output logic             rp_ok_o
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
        end else if (pre_i) begin
            open_q <= 1'b0;
        end
    end

    assign open_o = open_q;
    assign row_o  = row_q;

    ddr2_gap_timer #(.GAP(TRCD)) u_rcd (
        .clk(clk), .rst(rst), .start_i(act_i), .ok_o(rcd_ok_o));
    ddr2_gap_timer #(.GAP(TRTP)) u_rtp (
        .clk(clk), .rst(rst), .start_i(rd_i),  .ok_o(rtp_ok_o));
    ddr2_gap_timer #(.GAP(TRP))  u_rp  (
        .clk(clk), .rst(rst), .start_i(pre_i), .ok_o(rp_ok_o));

    a_r1_read_needs_open: assert property (@(posedge clk) disable iff (rst)
        rd_i |-> open_q);
    a_r5_act_needs_closed: assert property (@(posedge clk) disable iff (rst)
        act_i |-> !open_q);
    a_r5_pre_needs_open: assert property (@(posedge clk) disable iff (rst)
        pre_i |-> open_q);
    a_r6_one_cmd_per_bank: assert property (@(posedge clk) disable iff (rst)
        $countones({act_i, rd_i, pre_i}) <= 1);

endmodule

// File: rtl/ddr2_rd_sched.sv
module ddr2_rd_sched
    import ddr2_sched_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int DEPTH  = 4,     // power of two
    parameter int TRRD   = 2,
    parameter int TRCD   = 3,
    parameter int TRTP   = 2,
    parameter int TRP    = 3,
    parameter int BURST  = 4,
    parameter int CL     = 3,
    localparam int ADDR_W = max_i(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              data_due_o
);
    localparam int NBANK = 1 << BANK_W;
    localparam int CCD   = BURST / 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } rd_req_t;

    localparam int REQ_W = $bits(rd_req_t);

    // ---------------- request queue ----------------
    rd_req_t          in_e, head_e, nxt_e;
    logic [CNT_W-1:0] q_cnt;
    logic             push, pop;

    assign in_e        = '{bank: req_bank_i, row: req_row_i, col: req_col_i};
    assign req_ready_o = (q_cnt < CNT_W'(DEPTH));
    assign push        = req_valid_i && req_ready_o;

    ddr2_req_fifo #(.W(REQ_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push_i(push), .push_data_i(in_e),
        .pop_i(pop),
        .head_o(head_e), .next_o(nxt_e), .cnt_o(q_cnt));

    logic nxt_col_unused;
    assign nxt_col_unused = ^nxt_e.col;

    // ---------------- per-bank state ----------------
    ddr_cmd_e          sel_cmd;
    logic [BANK_W-1:0] sel_bank;
    logic [ADDR_W-1:0] sel_addr;

    logic [NBANK-1:0]  bank_open, rcd_ok, rtp_ok, rp_ok;
    logic [ROW_W-1:0]  bank_row [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_b;
        assign hit_b = (sel_bank == BANK_W'(b));
        ddr2_bank_track #(.ROW_W(ROW_W), .TRCD(TRCD), .TRTP(TRTP), .TRP(TRP)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act_i   (hit_b && sel_cmd == CMD_ACT),
            .rd_i    (hit_b && sel_cmd == CMD_READ),
            .pre_i   (hit_b && sel_cmd == CMD_PRE),
            .row_i   (sel_addr[ROW_W-1:0]),
            .open_o  (bank_open[b]),
            .row_o   (bank_row[b]),
            .rcd_ok_o(rcd_ok[b]),
            .rtp_ok_o(rtp_ok[b]),
            .rp_ok_o (rp_ok[b]));
    end

    // ---------------- bus-wide gaps ----------------
    logic rrd_ok, ccd_ok;

    ddr2_gap_timer #(.GAP(TRRD)) u_rrd (
        .clk(clk), .rst(rst), .start_i(sel_cmd == CMD_ACT),  .ok_o(rrd_ok));
    ddr2_gap_timer #(.GAP(CCD))  u_ccd (
        .clk(clk), .rst(rst), .start_i(sel_cmd == CMD_READ), .ok_o(ccd_ok));

    // ---------------- command choice ----------------
    logic [BANK_W-1:0] hb, nb;
    assign hb = head_e.bank;
    assign nb = nxt_e.bank;

    always_comb begin
        sel_cmd  = CMD_NOP;
        sel_bank = '0;
        sel_addr = '0;
        pop      = 1'b0;
        if (q_cnt != '0) begin
            if (bank_open[hb] && bank_row[hb] == head_e.row) begin
                if (rcd_ok[hb] && ccd_ok) begin
                    sel_cmd  = CMD_READ;
                    sel_bank = hb;
                    sel_addr = ADDR_W'(head_e.col);
                    pop      = 1'b1;
                end
            end else if (bank_open[hb]) begin
                if (rtp_ok[hb]) begin
                    sel_cmd  = CMD_PRE;
                    sel_bank = hb;
                end
            end else if (rp_ok[hb] && rrd_ok) begin
                sel_cmd  = CMD_ACT;
                sel_bank = hb;
                sel_addr = ADDR_W'(head_e.row);
            end
        end
        // early activate for the second request
        if (sel_cmd == CMD_NOP && q_cnt > CNT_W'(1) && nb != hb &&
            !bank_open[nb] && rp_ok[nb] && rrd_ok) begin
            sel_cmd  = CMD_ACT;
            sel_bank = nb;
            sel_addr = ADDR_W'(nxt_e.row);
        end
    end

    // ---------------- registered command bus ----------------
    ddr_cmd_e          cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CL-1:0]     due_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            due_sh <= '0;
        end else begin
            cmd_q     <= sel_cmd;
            bank_q    <= sel_bank;
            addr_q    <= sel_addr;
            due_sh[0] <= (cmd_q == CMD_READ);
            for (int i = 1; i < CL; i++) due_sh[i] <= due_sh[i-1];
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign cmd_addr_o = addr_q;
    assign data_due_o = due_sh[CL-1];

    a_r6_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_NOP) |-> (bank_q == '0 && addr_q == '0));
    a_r6_pre_no_addr: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE) |-> (addr_q == '0));

    if (TRRD >= 2) begin : g_rrd_chk
        a_r3_act_gap: assert property (@(posedge clk) disable iff (rst)
            (cmd_q == CMD_ACT) |=> (cmd_q != CMD_ACT));
    end
    if (CCD >= 2) begin : g_ccd_chk
        a_r4_read_gap: assert property (@(posedge clk) disable iff (rst)
            (cmd_q == CMD_READ) |=> (cmd_q != CMD_READ));
    end

endmodule

// File: tb/ddr2_rd_sched_tb.sv
`timescale 1ns/1ps
module ddr2_rd_sched_tb_top;
    localparam int BANK_W = 3, ROW_W = 14, COL_W = 10, DEPTH = 4;
    localparam int TRRD = 2, TRCD = 3, TRTP = 2, TRP = 3, CL = 3, CCD = 2;
    localparam int NB = 8;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_PRE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic req_ready;
    logic [1:0] cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [13:0] cmd_addr;
    logic data_due;

    always #4 clk = ~clk;

    ddr2_rd_sched dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
        .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
        .data_due_o(data_due));

    int n_vec = 0, n_bad = 0;
    bit chk_on = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model (timestamps and queues) ----------------
    int q_bank[$], q_row[$], q_col[$];
    int due_q[$];
    int open_row[NB];
    int t_act[NB], t_rd[NB], t_pre[NB];
    int t_lact, t_lrd, cyc;
    int e_cmd, e_bank, e_addr;

    always @(posedge clk) begin
        if (rst) begin
            q_bank.delete(); q_row.delete(); q_col.delete(); due_q.delete();
            for (int b = 0; b < NB; b++) begin
                open_row[b] = -1; t_act[b] = -1000; t_rd[b] = -1000; t_pre[b] = -1000;
            end
            t_lact = -1000; t_lrd = -1000; cyc = 0;
            e_cmd = C_NOP; e_bank = 0; e_addr = 0;
        end else begin
            int sz, hbk, nbk;
            bit acc;
            cyc++;
            sz  = q_bank.size();
            acc = req_valid && (sz < DEPTH);
            e_cmd = C_NOP; e_bank = 0; e_addr = 0;
            if (sz > 0) begin
                hbk = q_bank[0];
                if (open_row[hbk] == q_row[0]) begin
                    if (cyc - t_act[hbk] >= TRCD && cyc - t_lrd >= CCD) begin
                        e_cmd = C_RD; e_bank = hbk; e_addr = q_col[0];
                    end
                end else if (open_row[hbk] >= 0) begin
                    if (cyc - t_rd[hbk] >= TRTP) begin e_cmd = C_PRE; e_bank = hbk; end
                end else if (cyc - t_pre[hbk] >= TRP && cyc - t_lact >= TRRD) begin
                    e_cmd = C_ACT; e_bank = hbk; e_addr = q_row[0];
                end
                if (e_cmd == C_NOP && sz > 1) begin
                    nbk = q_bank[1];
                    if (nbk != hbk && open_row[nbk] < 0 &&
                        cyc - t_pre[nbk] >= TRP && cyc - t_lact >= TRRD) begin
                        e_cmd = C_ACT; e_bank = nbk; e_addr = q_row[1];
                    end
                end
            end
            case (e_cmd)
                C_ACT: begin open_row[e_bank] = e_addr; t_act[e_bank] = cyc; t_lact = cyc; end
                C_PRE: begin open_row[e_bank] = -1; t_pre[e_bank] = cyc; end
                C_RD: begin
                    t_rd[e_bank] = cyc; t_lrd = cyc; due_q.push_back(cyc + CL);
                    void'(q_bank.pop_front()); void'(q_row.pop_front()); void'(q_col.pop_front());
                end
                default: ;
            endcase
            if (acc) begin
                q_bank.push_back(int'(req_bank));
                q_row.push_back(int'(req_row));
                q_col.push_back(int'(req_col));
            end
        end
    end

    function automatic string tag_of(input int c);
        case (c)
            C_ACT: return "R3";
            C_RD:  return "R4";
            C_PRE: return "R5";
            default: return "R6";
        endcase
    endfunction

    // ---------------- per-cycle compare and command log ----------------
    typedef struct { int t; int c; int b; } ev_t;
    ev_t ev_log[$];
    int  due_seen = 0;

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            bit e_due;
            e_due = (due_q.size() > 0 && due_q[0] == cyc);
            if (e_due) void'(due_q.pop_front());
            chk(int'(cmd) == e_cmd, tag_of(e_cmd), "command", int'(cmd), e_cmd);
            chk(int'(cmd_bank) == e_bank, "R6", "bank", int'(cmd_bank), e_bank);
            chk(int'(cmd_addr) == e_addr, "R6", "address", int'(cmd_addr), e_addr);
            chk(req_ready == (q_bank.size() < DEPTH), "R9", "ready",
                int'(req_ready), int'(q_bank.size() < DEPTH));
            chk(data_due == e_due, "R7", "data due", int'(data_due), int'(e_due));
            if (cmd != 2'd0) ev_log.push_back('{cyc, int'(cmd), int'(cmd_bank)});
            if (data_due) due_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int b, input int r, input int c);
        bit took;
        req_valid = 1'b1;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(r);
        req_col   = COL_W'(c);
        forever begin
            took = req_ready;
            @(posedge clk);
            @(negedge clk);
            if (took) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int count_cmd(input int c);
        int n = 0;
        foreach (ev_log[i]) if (ev_log[i].c == c) n++;
        return n;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cmd == 2'd0, "R10", "reset command", int'(cmd), 0);
        chk(req_ready == 1'b1, "R10", "reset ready", int'(req_ready), 1);
        chk(data_due == 1'b0, "R10", "reset data due", int'(data_due), 0);
        rst = 1'b0;
        chk_on = 1'b1;

        // R1: page hits after a single activate
        send(0, 5, 1); send(0, 5, 2); send(0, 5, 3);
        idle(20);
        chk(count_cmd(C_ACT) == 1, "R1", "activates for hit run", count_cmd(C_ACT), 1);
        chk(count_cmd(C_RD) == 3, "R1", "reads for hit run", count_cmd(C_RD), 3);
        chk(count_cmd(C_PRE) == 0, "R1", "precharges for hit run", count_cmd(C_PRE), 0);

        // mixed miss/hit/conflict sequence: pre-open bank 2 with row 7
        send(2, 7, 0);
        idle(20);
        ev_log.delete();
        due_seen = 0;
        send(4, 1, 10); send(5, 2, 11); send(2, 7, 12); send(2, 9, 13);
        idle(30);
        chk(ev_log.size() == 8, "R8", "command count in mixed run", ev_log.size(), 8);
        if (ev_log.size() == 8) begin
            chk(ev_log[1].t - ev_log[0].t == TRRD, "R3", "ACT to ACT gap",
                ev_log[1].t - ev_log[0].t, TRRD);
            chk(ev_log[2].c == C_RD && ev_log[2].t - ev_log[0].t == TRCD, "R2",
                "ACT to READ gap", ev_log[2].t - ev_log[0].t, TRCD);
            chk(ev_log[3].t - ev_log[2].t == CCD, "R4", "READ to READ gap (banks differ)",
                ev_log[3].t - ev_log[2].t, CCD);
            chk(ev_log[4].t - ev_log[3].t == CCD, "R4", "READ to READ gap (hit)",
                ev_log[4].t - ev_log[3].t, CCD);
            chk(ev_log[5].c == C_PRE && ev_log[5].t - ev_log[4].t == TRTP, "R5",
                "READ to PRE gap", ev_log[5].t - ev_log[4].t, TRTP);
            chk(ev_log[6].c == C_ACT && ev_log[6].t - ev_log[5].t == TRP, "R5",
                "PRE to ACT gap", ev_log[6].t - ev_log[5].t, TRP);
            chk(ev_log[2].b == 4 && ev_log[3].b == 5 && ev_log[4].b == 2 && ev_log[7].b == 2,
                "R8", "read order bank of first read", ev_log[2].b, 4);
            chk(ev_log[1].c == C_ACT && ev_log[1].b == 5, "R8", "early activate bank",
                ev_log[1].b, 5);
        end
        chk(due_seen == count_cmd(C_RD), "R7", "data due pulses", due_seen, count_cmd(C_RD));

        // R9: fill the queue with a slow conflicting run on bank 3
        send(3, 1, 0); send(3, 2, 0); send(3, 1, 1); send(3, 2, 1);
        chk(req_ready == 1'b0, "R9", "ready when full", int'(req_ready), 0);
        send(3, 1, 2);
        idle(60);

        // random traffic with a small row set for hits and conflicts
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom % NB), int'($urandom % 3), int'($urandom % 1024));
            if ($urandom % 5 == 0) idle(int'($urandom % 6));
        end
        idle(60);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule